// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry

This block is the control core of a small word-addressed processor. It walks every instruction through a fixed series of phases: it forms the fetch address, reads the instruction word, decodes it, forms operand addresses, reads operands, performs the data operation, writes a result back, and finally checks for a pending interrupt. Memory is reached through one single-word port. An address register drives the address and a buffer register holds the write data or takes the read data. Read data is taken in the same cycle that the read strobe is high.

Each instruction selects which operand phases it uses. Phases an instruction does not need are skipped, and the address and read phases are repeated when an instruction needs two operands. After each instruction the sequencer checks four request lines. If a request is pending and interrupts are enabled, it saves the program counter and the flags word to two fixed memory words and jumps to a per-class handler. A return opcode reads the saved context back and enables interrupts again.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: Synchronous active-high `rst` sets the program counter to 0, the phase to address calculation (`phase_o` = 1), interrupts to enabled, and holds `mem_rd`, `mem_wr` and `irq_ack` low.
- R2: `phase_o` is one-hot with bit 0 address calc, 1 fetch, 2 decode, 3 operand address, 4 operand read, 5 data operation, 6 operand write, 7 interrupt check, 8 save PC, 9 save flags, 10 vector load. The phases from address calc through interrupt check take 5 cycles for opcodes 0, 5 and 7..15, 7 cycles for opcodes 1, 2 and 4, and 9 cycles for opcodes 3 and 6.
- R3: In the fetch phase `mem_rd` is high and `mem_addr` equals the program counter. The word read becomes the instruction, and the program counter advances by one.
- R4: An instruction word carries its opcode in bits [15:12] and an address field in bits [11:0]. Opcodes 0 (no-op), 5 and 7..15 (treated as no-ops) skip all operand phases.
- R5: Opcode 3 visits the operand address and operand read phases twice, reading the field address and then the field address plus one.
- R6: Opcode 1 loads the accumulator from memory. Opcode 2 adds one memory word to it, and opcode 3 adds two words. The zero flag (bit 0 of the flags word) marks a zero result. The carry flag (bit 1) marks a carry out of 16 bits and is cleared by a load.
- R7: Opcode 4 runs the data operation first, then an operand address phase and a write phase that stores the accumulator at the field address.
- R8: Opcode 5 sets the program counter to the address field.
- R9: Requests are sampled only in the interrupt check phase and only while interrupts are enabled. Otherwise the next phase is address calculation and the request stays pending.
- R10: When several lines are active, line 0 (hardware failure) wins, then line 1 (program), line 2 (timer) and line 3 (I/O). `irq_ack` shows the winner one-hot for the single save-PC cycle.
- R11: Interrupt entry writes the program counter to word 0xFF0, then the flags word to 0xFF1. It clears the enable and loads the program counter with 0xF00 + 16 x line index.
- R12: Opcode 6 reads 0xFF0 into the program counter and 0xFF1 into the flags, and enables interrupts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address from the address register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Write data from the buffer register |
| mem_rdata | input | 16 | Read data, taken in the cycle the read strobe is high |
| irq_req | input | 4 | Request lines: 0 hardware failure, 1 program, 2 timer, 3 I/O |
| irq_ack | output | 4 | One-hot acknowledge of the granted line |
| phase_o | output | 11 | One-hot phase strobes |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| acc_o | output | 16 | Accumulator |

## Verification
Two functions can land in the same cycle. The first pair is a redirect of the program counter by a jump or return and the interrupt check that follows it. The second pair is the enable restored by a return and a request that is already waiting. The bench holds request lines at random times across random programs, and it raises several lines together right after handlers. This provokes both pairs. A reference model judges each case. The saved word must be the redirected address, and a request waiting at a return must be taken at once in that return's check phase.

// File: rtl/icc_pkg.sv
package icc_pkg;

    typedef enum logic [3:0] {
        ST_IAC = 4'd0,
        ST_IF  = 4'd1,
        ST_IOD = 4'd2,
        ST_OAC = 4'd3,
        ST_OF  = 4'd4,
        ST_DO  = 4'd5,
        ST_OS  = 4'd6,
        ST_ICK = 4'd7,
        ST_SPC = 4'd8,
        ST_SFL = 4'd9,
        ST_VEC = 4'd10
    } phase_e;

    localparam int NUM_PHASES = 11;

    localparam logic [3:0] OPC_NOP   = 4'd0;
    localparam logic [3:0] OPC_LOAD  = 4'd1;
    localparam logic [3:0] OPC_ADD   = 4'd2;
    localparam logic [3:0] OPC_ADD2  = 4'd3;
    localparam logic [3:0] OPC_STORE = 4'd4;
    localparam logic [3:0] OPC_JUMP  = 4'd5;
    localparam logic [3:0] OPC_RETI  = 4'd6;

    typedef enum logic [2:0] {
        EX_NONE,
        EX_LOAD,
        EX_ADD,
        EX_STORE,
        EX_JUMP,
        EX_RETI
    } exop_e;

    typedef struct packed {
        logic [1:0] nfetch;  // operand reads required
        logic       two;     // add uses both operands
        logic       ctx;     // operand addresses point at the context words
        logic       store;   // a write phase follows the data operation
        exop_e      ex;
    } dec_t;

endpackage

// File: rtl/icc_decode.sv
module icc_decode
    import icc_pkg::*;
(
    input  logic [3:0] opc_i,
    output dec_t       dec_o
);
    always_comb begin
        dec_o.nfetch = 2'd0;
        dec_o.two    = 1'b0;
        dec_o.ctx    = 1'b0;
        dec_o.store  = 1'b0;
        dec_o.ex     = EX_NONE;
        case (opc_i)
            OPC_LOAD: begin
                dec_o.nfetch = 2'd1;
                dec_o.ex     = EX_LOAD;
            end
            OPC_ADD: begin
                dec_o.nfetch = 2'd1;
                dec_o.ex     = EX_ADD;
            end
            OPC_ADD2: begin
                dec_o.nfetch = 2'd2;
                dec_o.two    = 1'b1;
                dec_o.ex     = EX_ADD;
            end
            OPC_STORE: begin
                dec_o.store = 1'b1;
                dec_o.ex    = EX_STORE;
            end
            OPC_JUMP: begin
                dec_o.ex = EX_JUMP;
            end
            OPC_RETI: begin
                dec_o.nfetch = 2'd2;
                dec_o.ctx    = 1'b1;
                dec_o.ex     = EX_RETI;
            end
            default: begin
                dec_o.ex = EX_NONE;
            end
        endcase
    end
endmodule

// File: rtl/icc_irq_arb.sv
module icc_irq_arb #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o
);
    // lower line index has higher priority
    for (genvar g = 0; g < N; g++) begin : g_gnt
        if (g == 0) begin : g_top
            assign grant_o[g] = req_i[g];
        end else begin : g_lower
            assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
        end
    end

    assign any_o = |req_i;

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/icc_opnd_addr.sv
module icc_opnd_addr #(
    parameter int             AW       = 12,
    parameter logic [AW-1:0]  CTX_BASE = 12'hFF0
) (
    input  logic [AW-1:0] field_i,
    input  logic          idx_i,
    input  logic          ctx_i,
    input  logic          store_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] base;

    always_comb begin
        base   = ctx_i ? CTX_BASE : field_i;
        addr_o = store_i ? field_i : (base + AW'(idx_i));
    end
endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
    import icc_pkg::*;
#(
    parameter int            DW        = 16,
    parameter int            AW        = 12,
    parameter int            NIRQ      = 4,
    parameter logic [AW-1:0] CTX_BASE  = 12'hFF0,
    parameter logic [AW-1:0] VEC_BASE  = 12'hF00,
    parameter int            VEC_SHIFT = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [AW-1:0]         mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [DW-1:0]         mem_wdata,
    input  logic [DW-1:0]         mem_rdata,
    input  logic [NIRQ-1:0]       irq_req,
    output logic [NIRQ-1:0]       irq_ack,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic [AW-1:0]         pc_o,
    output logic [DW-1:0]         ir_o,
    output logic [DW-1:0]         acc_o
);
    localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
    localparam int OPW  = 4;

    typedef struct packed {
        phase_e          st;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   mar;
        logic [DW-1:0]   mbr;
        logic [DW-1:0]   ir;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   op0;
        logic [DW-1:0]   op1;
        logic            zf;
        logic            cf;
        logic            ie;
        logic            fidx;
        logic [1:0]      left;
        logic            store_ph;
        logic [IDXW-1:0] gsel;
        logic [NIRQ-1:0] gnt;
    } regs_t;

    regs_t r_q, r_d;

    dec_t            dec;
    logic            irq_any;
    logic [NIRQ-1:0] irq_gnt;
    logic [IDXW-1:0] irq_idx;
    logic [AW-1:0]   opnd_addr;
    logic [DW+1:0]   sum;

    icc_decode u_dec (
        .opc_i (r_q.ir[DW-1:DW-OPW]),
        .dec_o (dec)
    );

    icc_irq_arb #(.N(NIRQ)) u_arb (
        .req_i   (irq_req),
        .any_o   (irq_any),
        .grant_o (irq_gnt),
        .idx_o   (irq_idx)
    );

    icc_opnd_addr #(.AW(AW), .CTX_BASE(CTX_BASE)) u_oaddr (
        .field_i (r_q.ir[AW-1:0]),
        .idx_i   (r_q.fidx),
        .ctx_i   (dec.ctx),
        .store_i (r_q.store_ph),
        .addr_o  (opnd_addr)
    );

    always_comb begin
        r_d = r_q;
        sum = {2'b00, r_q.acc} + {2'b00, r_q.op0}
            + (dec.two ? {2'b00, r_q.op1} : '0);
        case (r_q.st)
            ST_IAC: begin
                r_d.mar = r_q.pc;
                r_d.st  = ST_IF;
            end
            ST_IF: begin
                r_d.ir = mem_rdata;
                r_d.pc = r_q.pc + 1'b1;
                r_d.st = ST_IOD;
            end
            ST_IOD: begin
                r_d.left     = dec.nfetch;
                r_d.fidx     = 1'b0;
                r_d.store_ph = 1'b0;
                r_d.st       = (dec.nfetch != 2'd0) ? ST_OAC : ST_DO;
            end
            ST_OAC: begin
                r_d.mar = opnd_addr;
                r_d.st  = r_q.store_ph ? ST_OS : ST_OF;
            end
            ST_OF: begin
                r_d.mbr = mem_rdata;
                if (r_q.fidx) r_d.op1 = mem_rdata;
                else          r_d.op0 = mem_rdata;
                r_d.fidx = 1'b1;
                r_d.left = r_q.left - 2'd1;
                r_d.st   = (r_q.left == 2'd1) ? ST_DO : ST_OAC;
            end
            ST_DO: begin
                case (dec.ex)
                    EX_LOAD: begin
                        r_d.acc = r_q.op0;
                        r_d.zf  = (r_q.op0 == '0);
                        r_d.cf  = 1'b0;
                    end
                    EX_ADD: begin
                        r_d.acc = sum[DW-1:0];
                        r_d.zf  = (sum[DW-1:0] == '0);
                        r_d.cf  = |sum[DW+1:DW];
                    end
                    EX_STORE: r_d.mbr = r_q.acc;
                    EX_JUMP:  r_d.pc  = r_q.ir[AW-1:0];
                    EX_RETI: begin
                        r_d.pc = r_q.op0[AW-1:0];
                        r_d.zf = r_q.op1[0];
                        r_d.cf = r_q.op1[1];
                        r_d.ie = 1'b1;
                    end
                    default: ;
                endcase
                if (dec.store) begin
                    r_d.store_ph = 1'b1;
                    r_d.st       = ST_OAC;
                end else begin
                    r_d.st = ST_ICK;
                end
            end
            ST_OS: begin
                r_d.st = ST_ICK;
            end
            ST_ICK: begin
                if (r_q.ie && irq_any) begin
                    r_d.gnt  = irq_gnt;
                    r_d.gsel = irq_idx;
                    r_d.ie   = 1'b0;
                    r_d.mar  = CTX_BASE;
                    r_d.mbr  = DW'(r_q.pc);
                    r_d.st   = ST_SPC;
                end else begin
                    r_d.st = ST_IAC;
                end
            end
            ST_SPC: begin
                r_d.mar = CTX_BASE + 1'b1;
                r_d.mbr = {{(DW-2){1'b0}}, r_q.cf, r_q.zf};
                r_d.st  = ST_SFL;
            end
            ST_SFL: begin
                r_d.st = ST_VEC;
            end
            ST_VEC: begin
                r_d.pc = VEC_BASE + (AW'(r_q.gsel) << VEC_SHIFT);
                r_d.st = ST_IAC;
            end
            default: r_d.st = ST_IAC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_IAC;
            r_q.ie <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        assign phase_o[g] = (r_q.st == phase_e'(g));
    end

    assign mem_addr  = r_q.mar;
    assign mem_wdata = r_q.mbr;
    assign mem_rd    = (r_q.st == ST_IF) || (r_q.st == ST_OF);
    assign mem_wr    = (r_q.st == ST_OS) || (r_q.st == ST_SPC) || (r_q.st == ST_SFL);
    assign irq_ack   = (r_q.st == ST_SPC) ? r_q.gnt : '0;
    assign pc_o      = r_q.pc;
    assign ir_o      = r_q.ir;
    assign acc_o     = r_q.acc;

endmodule

// File: rtl/icc_checker.sv
module icc_checker
    import icc_pkg::*;
#(
    parameter int AW   = 12,
    parameter int NIRQ = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_PHASES-1:0] phase_o,
    input logic                  mem_rd,
    input logic                  mem_wr,
    input logic [NIRQ-1:0]       irq_req,
    input logic [NIRQ-1:0]       irq_ack,
    input logic [AW-1:0]         pc_o
);
    localparam int P_IAC = int'(ST_IAC);
    localparam int P_IF  = int'(ST_IF);
    localparam int P_OS  = int'(ST_OS);
    localparam int P_ICK = int'(ST_ICK);
    localparam int P_SPC = int'(ST_SPC);
    localparam int P_SFL = int'(ST_SFL);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && phase_o[P_IAC] && !mem_rd && !mem_wr && irq_ack == '0));

    a_r2_phase_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_o) == 1);

    a_r2_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r3_fetch_advances_pc: assert property (@(posedge clk) disable iff (rst)
        phase_o[P_IF] |=> (pc_o == AW'($past(pc_o) + 1'b1)));

    a_r9_check_exit: assert property (@(posedge clk) disable iff (rst)
        phase_o[P_ICK] |=> (phase_o[P_IAC] || phase_o[P_SPC]));

    a_r9_ack_after_check: assert property (@(posedge clk) disable iff (rst)
        (irq_ack != '0) |-> $past(phase_o[P_ICK]));

    a_r10_ack_priority: assert property (@(posedge clk) disable iff (rst)
        (irq_ack != '0) |-> ($countones(irq_ack) == 1
                             && (irq_ack & $past(irq_req)) == irq_ack
                             && ((irq_ack - 1'b1) & $past(irq_req)) == '0));

    a_r11_write_phases: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (phase_o[P_OS] || phase_o[P_SPC] || phase_o[P_SFL]));

endmodule

bind instr_cycle_ctrl icc_checker #(.AW(AW), .NIRQ(NIRQ)) u_checker (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase_o),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .irq_req (irq_req),
    .irq_ack (irq_ack),
    .pc_o    (pc_o)
);

// File: tb/instr_cycle_ctrl_tb_top.sv
module instr_cycle_ctrl_tb_top;
    import icc_pkg::*;

    localparam int P_IAC = int'(ST_IAC);
    localparam int P_IF  = int'(ST_IF);
    localparam int P_ICK = int'(ST_ICK);
    localparam int P_SPC = int'(ST_SPC);
    localparam int P_SFL = int'(ST_SFL);
    localparam logic [11:0] CTX  = 12'hFF0;
    localparam logic [11:0] VEC  = 12'hF00;
    localparam int          NINS = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [3:0]  irq_req = 4'h0;
    logic [3:0]  irq_ack;
    logic [10:0] phase_o;
    logic [11:0] pc_o;
    logic [15:0] ir_o, acc_o;

    always #2 clk = ~clk;

    instr_cycle_ctrl dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_req(irq_req), .irq_ack(irq_ack),
        .phase_o(phase_o), .pc_o(pc_o), .ir_o(ir_o), .acc_o(acc_o)
    );

    logic [15:0] mem [0:4095];
    logic [15:0] gm  [0:4095];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    int n_chk = 0, n_bad = 0, ninstr = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model state
    logic [11:0] mpc = 12'h000;
    logic [15:0] macc = 16'h0;
    logic        mzf = 1'b0, mcf = 1'b0, mie = 1'b1;
    int          cnt = 0, int_step = 0, elen = 0;
    bit          ign_pend = 0;
    logic [3:0]  exp_ack;
    logic [15:0] exp_spc, exp_sfl;

    function automatic int lowest(input logic [3:0] r);
        for (int i = 3; i >= 0; i--) if (r[i]) lowest = i;
    endfunction

    task automatic model_step();
        logic [15:0] ins;
        logic [3:0]  opc;
        logic [11:0] fa;
        logic [17:0] s;
        string       ptag;
        int          sel;
        ins = gm[mpc]; opc = ins[15:12]; fa = ins[11:0];
        mpc = mpc + 12'd1;
        ptag = "R3";
        elen = 5;
        case (opc)
            4'd1: begin macc = gm[fa]; mzf = (macc == 0); mcf = 1'b0; elen = 7; end
            4'd2: begin
                s = {2'b0, macc} + {2'b0, gm[fa]};
                macc = s[15:0]; mzf = (macc == 0); mcf = |s[17:16]; elen = 7;
            end
            4'd3: begin
                s = {2'b0, macc} + {2'b0, gm[fa]} + {2'b0, gm[fa + 12'd1]};
                macc = s[15:0]; mzf = (macc == 0); mcf = |s[17:16]; elen = 9;
            end
            4'd4: begin gm[fa] = macc; elen = 7; end
            4'd5: begin mpc = fa; ptag = "R8"; end
            4'd6: begin
                mpc = gm[CTX][11:0]; mzf = gm[CTX + 12'd1][0]; mcf = gm[CTX + 12'd1][1];
                mie = 1'b1; elen = 9; ptag = "R12";
            end
            default: elen = 5;
        endcase
        chk(cnt == elen, (opc == 4'd3) ? "R5" : "R2", "phases per instruction", cnt, elen);
        chk(pc_o == mpc, ptag, "program counter after execute", pc_o, mpc);
        chk(acc_o == macc, "R6", "accumulator", acc_o, macc);
        if (irq_req != 4'h0) begin
            if (mie) begin
                sel     = lowest(irq_req);
                exp_ack = 4'b1 << sel;
                exp_spc = {4'h0, mpc};
                exp_sfl = {14'h0, mcf, mzf};
                gm[CTX] = exp_spc;
                gm[CTX + 12'd1] = exp_sfl;
                mpc = VEC + 12'(sel * 16);
                mie = 1'b0;
                int_step = 1;
            end else begin
                ign_pend = 1;
            end
        end
        ninstr++;
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (phase_o[P_IAC]) cnt = 1; else cnt = cnt + 1;
            if (ign_pend) begin
                chk(phase_o[P_IAC] && !mem_wr, "R9", "masked request left sequence alone", phase_o, 1);
                ign_pend = 0;
            end
            if (int_step == 1) begin
                chk(phase_o[P_SPC] && mem_wr && mem_addr == CTX, "R11", "pc save address", mem_addr, CTX);
                chk(mem_wdata == exp_spc, "R11", "saved pc", mem_wdata, exp_spc);
                chk(irq_ack == exp_ack, "R10", "acknowledge", irq_ack, exp_ack);
                int_step = 2;
            end else if (int_step == 2) begin
                chk(phase_o[P_SFL] && mem_wr && mem_addr == CTX + 12'd1, "R11", "flags save address", mem_addr, CTX + 12'd1);
                chk(mem_wdata == exp_sfl, "R6", "saved flags word", mem_wdata, exp_sfl);
                int_step = 0;
            end
            if (phase_o[P_IF])
                chk(mem_rd && mem_addr == mpc, "R3", "fetch address", mem_addr, mpc);
            if (phase_o[P_ICK]) model_step();
        end
    end

    // request driver: lines are held until acknowledged
    initial begin
        bit b1 = 0, b2 = 0;
        wait (!rst);
        forever begin
            @(posedge clk); #1;
            if (irq_ack != 4'h0) irq_req = irq_req & ~irq_ack;
            else if (ninstr >= 400 && !b1) begin irq_req = 4'hF; b1 = 1; end   // R10 all lines at once
            else if (ninstr >= 1500 && !b2) begin irq_req = 4'hC; b2 = 1; end  // R10 timer beats I/O
            else if ($urandom % 50 == 0) irq_req = irq_req | (4'b1 << ($urandom % 4));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d instructions expected %0d", ninstr, NINS);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'd20240611));
        for (int a = 0; a < 4096; a++) mem[a] = 16'h0000;
        for (int a = 12'h800; a < 12'hA00; a++) mem[a] = 16'($urandom);
        for (int a = 0; a < 255; a++) begin
            r = $urandom % 16;
            if (r < 2)        mem[a] = {4'd0, 12'($urandom)};
            else if (r < 4)   mem[a] = {4'd1, 12'h800 + 12'($urandom % 256)};
            else if (r < 7)   mem[a] = {4'd2, 12'h800 + 12'($urandom % 256)};
            else if (r < 9)   mem[a] = {4'd3, 12'h800 + 12'($urandom % 255)};
            else if (r < 12)  mem[a] = {4'd4, 12'h800 + 12'($urandom % 256)};
            else if (r < 13)  mem[a] = {4'd5, 12'($urandom % 256)};
            else if (r < 14)  mem[a] = {4'd7 + 4'($urandom % 9), 12'($urandom)};  // R4 undefined codes
            else              mem[a] = {4'd2, 12'h900 + 12'($urandom % 256)};
        end
        mem[255] = {4'd5, 12'h000};
        for (int k = 0; k < 4; k++) begin
            mem[VEC + 16 * k]     = {4'd2, 12'h900 + 12'(k)};
            mem[VEC + 16 * k + 1] = {4'd4, 12'h9F0 + 12'(k)};
            mem[VEC + 16 * k + 2] = {4'd6, 12'h000};
        end
        for (int a = 0; a < 4096; a++) gm[a] = mem[a];

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc_o == 12'h0 && phase_o == 11'h1 && !mem_rd && !mem_wr && irq_ack == 4'h0,
            "R1", "reset state", {pc_o, phase_o}, {12'h0, 11'h1});
        @(posedge clk); #1 rst = 1'b0;

        while (ninstr < NINS && !finished) @(posedge clk);
        if (!finished) begin
            finished = 1;
            @(negedge clk);
            for (int a = 12'h800; a < 12'hA00; a++)
                chk(mem[a] == gm[a], "R7", "data memory word", mem[a], gm[a]);
            chk(mem[CTX] == gm[CTX], "R11", "context pc word", mem[CTX], gm[CTX]);
            chk(mem[CTX + 1] == gm[CTX + 1], "R11", "context flags word", mem[CTX + 1], gm[CTX + 1]);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule